// File: doc/BRIEF.md
# Sound Command Latch and Parser

This block sits between a host processor and a noise-synthesis engine. The host presents an 8-bit command byte and pulls an active-low strobe. The block synchronizes that strobe, accepts each byte once on its falling edge, and shows the latched byte as two 4-bit nibbles. The upper nibble of a command byte selects an action. Three actions fire a one-cycle play trigger, one for each of three sound types. One action sets a 4-bit volume for the third type. Three actions arm a parameter load, and the block then captures the next 4 or 5 strobed bytes into the register bank of the chosen type.

A separate router turns processor-style port writes into three 4-bit level outputs. A 5-bit write to the first port goes to channel 1 when its bit 4 is set and to channel 0 otherwise. A write to the second port drives channel 2.

Top module: `snd_cmd_parser`

## Requirements
- R1: After reset, the nibble outputs, all parameter banks, the volume and the three channels are zero, and no play trigger is high.
- R2: The strobe is synchronized through two flops and accepted on its falling edge only. One low period of any length accepts exactly one byte. If the strobe is first seen low just before clock edge k, the byte appears on cmd_hi (bits 7:4) and cmd_lo (bits 3:0) after edge k+2. Every accepted byte is shown this way, parameter bytes included.
- R3: An accepted command with upper nibble 1, 2 or 5 raises play_a, play_b or play_c for exactly one cycle, in the same cycle that the nibble outputs update. At most one trigger is high at a time.
- R4: Upper nibbles 0 and 8 to 15 leave the triggers, the volume and every parameter bank unchanged.
- R5: Upper nibble 3 claims the next 4 accepted bytes for bank A. Parameter byte k (counting from 0) lands in prm_a bits [8k+7:8k].
- R6: Upper nibble 4 claims the next 4 accepted bytes for bank B, using the same byte placement in prm_b.
- R7: Upper nibble 6 claims the next 5 accepted bytes for bank C, using the same byte placement in prm_c.
- R8: A byte claimed as a parameter is never decoded. Even if it looks like a play, volume or load command, it fires no trigger and leaves the volume unchanged.
- R9: Upper nibble 7 loads the command's low nibble into vol_c.
- R10: A first-port write places bits 3:0 on chan1 if bit 4 is 1, and on chan0 if bit 4 is 0. The other channel stays unchanged. The new value is visible after the clock edge that samples the write.
- R11: A second-port write places its 4 bits on chan2 after the sampling edge. It leaves chan0 and chan1 unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| host_data | input | 8 | Command or parameter byte from the host |
| host_stb_n | input | 1 | Active-low host strobe, asynchronous |
| port_o_wr | input | 1 | First output port write enable |
| port_o_data | input | 5 | First port data; bit 4 selects the channel |
| port_r_wr | input | 1 | Second output port write enable |
| port_r_data | input | 4 | Second port data |
| cmd_hi | output | 4 | Upper nibble of the last accepted byte |
| cmd_lo | output | 4 | Lower nibble of the last accepted byte |
| play_a | output | 1 | One-cycle trigger for sound type A |
| play_b | output | 1 | One-cycle trigger for sound type B |
| play_c | output | 1 | One-cycle trigger for sound type C |
| prm_a | output | 32 | Type A parameter bank, byte 0 in the low bits |
| prm_b | output | 32 | Type B parameter bank, byte 0 in the low bits |
| prm_c | output | 40 | Type C parameter bank, byte 0 in the low bits |
| vol_c | output | 4 | Type C volume |
| chan0 | output | 4 | Level channel 0 |
| chan1 | output | 4 | Level channel 1 |
| chan2 | output | 4 | Level channel 2 |

## Verification
The assertions assume that host_data is stable from the strobe's falling edge until at least three clocks later. They also assume that the strobe stays high for at least two clocks between bytes, so that each low period is seen as one falling edge. The bench holds every byte for the whole low period, keeps the strobe low for six clocks and high for four, and changes port inputs only on falling clock edges. Under these conditions the expected values follow from the byte order alone.

// File: rtl/snd_cmd_pkg.sv
package snd_cmd_pkg;

  localparam int BYTE_W = 8;
  localparam int NIB_W  = 4;

  localparam logic [NIB_W-1:0] OP_PLAY_A = 4'd1;
  localparam logic [NIB_W-1:0] OP_PLAY_B = 4'd2;
  localparam logic [NIB_W-1:0] OP_LOAD_A = 4'd3;
  localparam logic [NIB_W-1:0] OP_LOAD_B = 4'd4;
  localparam logic [NIB_W-1:0] OP_PLAY_C = 4'd5;
  localparam logic [NIB_W-1:0] OP_LOAD_C = 4'd6;
  localparam logic [NIB_W-1:0] OP_VOL_C  = 4'd7;

  typedef enum logic [1:0] {TGT_A = 2'd0, TGT_B = 2'd1, TGT_C = 2'd2} tgt_e;

  function automatic logic op_is_load(input logic [NIB_W-1:0] op);
    return (op == OP_LOAD_A) || (op == OP_LOAD_B) || (op == OP_LOAD_C);
  endfunction

  function automatic int load_len(input logic [NIB_W-1:0] op,
                                  input int na, input int nb, input int nc);
    case (op)
      OP_LOAD_A: return na;
      OP_LOAD_B: return nb;
      OP_LOAD_C: return nc;
      default:   return 0;
    endcase
  endfunction

  function automatic tgt_e load_target(input logic [NIB_W-1:0] op);
    case (op)
      OP_LOAD_B: return TGT_B;
      OP_LOAD_C: return TGT_C;
      default:   return TGT_A;
    endcase
  endfunction

  function automatic logic steer_hi(input logic [NIB_W:0] pdata);
    return pdata[NIB_W];
  endfunction

endpackage

// File: rtl/strobe_sync.sv
module strobe_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic stb_n,
  output logic evt_fall
);
  logic [SYNC_STAGES-1:0] sh;
  logic                   synced;
  logic                   prev;

  assign synced = sh[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh   <= '1;
      prev <= 1'b1;
    end else begin
      sh   <= {sh[SYNC_STAGES-2:0], stb_n};
      prev <= synced;
    end
  end

  assign evt_fall = prev & ~synced;

  // R2: one low period yields one accept event, never two in a row
  p_single_fall_r2: assert property (@(posedge clk) disable iff (!rst_n)
    evt_fall |=> !evt_fall);

endmodule

// File: rtl/param_bank.sv
module param_bank #(
  parameter int NBYTES = 4,
  parameter int IDX_W  = 3,
  localparam int BW    = snd_cmd_pkg::BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [IDX_W-1:0]  idx,
  input  logic [BW-1:0]     wdata,
  output logic [NBYTES*BW-1:0] bank
);
  for (genvar g = 0; g < NBYTES; g++) begin : g_byte
    logic [BW-1:0] q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          q <= '0;
      else if (wr && idx == IDX_W'(g))     q <= wdata;
    end
    assign bank[g*BW +: BW] = q;
  end

  // R5: the write index never runs past the bank
  p_idx_in_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wr |-> (idx < IDX_W'(NBYTES)));

  // R8: bank holds when nothing is written
  p_bank_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !wr |=> $stable(bank));

endmodule

// File: rtl/cmd_decoder.sv
module cmd_decoder
  import snd_cmd_pkg::*;
#(
  parameter int A_BYTES = 4,
  parameter int B_BYTES = 4,
  parameter int C_BYTES = 5,
  parameter int CNT_W   = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              evt_fall,
  input  logic [BYTE_W-1:0] din,
  output logic [BYTE_W-1:0] cmd_q,
  output logic              play_a,
  output logic              play_b,
  output logic              play_c,
  output logic              wr_a,
  output logic              wr_b,
  output logic              wr_c,
  output logic [CNT_W-1:0]  wr_idx,
  output logic [BYTE_W-1:0] wr_data,
  output logic [NIB_W-1:0]  vol
);
  localparam int MAXB = (A_BYTES > B_BYTES) ?
                        ((A_BYTES > C_BYTES) ? A_BYTES : C_BYTES) :
                        ((B_BYTES > C_BYTES) ? B_BYTES : C_BYTES);

  logic [CNT_W-1:0] remain;
  logic [CNT_W-1:0] idx;
  tgt_e             tgt;
  logic [NIB_W-1:0] op;
  logic             evt_param;
  logic             evt_cmd;

  assign op        = din[BYTE_W-1:NIB_W];
  assign evt_param = evt_fall && (remain != '0);
  assign evt_cmd   = evt_fall && (remain == '0);

  assign wr_a    = evt_param && (tgt == TGT_A);
  assign wr_b    = evt_param && (tgt == TGT_B);
  assign wr_c    = evt_param && (tgt == TGT_C);
  assign wr_idx  = idx;
  assign wr_data = din;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q  <= '0;
      remain <= '0;
      idx    <= '0;
      tgt    <= TGT_A;
      vol    <= '0;
      play_a <= 1'b0;
      play_b <= 1'b0;
      play_c <= 1'b0;
    end else begin
      play_a <= evt_cmd && (op == OP_PLAY_A);
      play_b <= evt_cmd && (op == OP_PLAY_B);
      play_c <= evt_cmd && (op == OP_PLAY_C);
      if (evt_fall) cmd_q <= din;
      if (evt_param) begin
        remain <= remain - 1'b1;
        idx    <= idx + 1'b1;
      end else if (evt_cmd) begin
        if (op_is_load(op)) begin
          remain <= CNT_W'(load_len(op, A_BYTES, B_BYTES, C_BYTES));
          idx    <= '0;
          tgt    <= load_target(op);
        end
        if (op == OP_VOL_C) vol <= din[NIB_W-1:0];
      end
    end
  end

  // R8: a claimed byte fires nothing and keeps the volume
  p_param_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    evt_param |=> (!(play_a || play_b || play_c) && $stable(vol)));

  // R7: the pending count never exceeds the largest bank
  p_remain_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
    remain <= CNT_W'(MAXB));

  // R5: a load opcode always arms a parameter run
  p_load_arms_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_cmd && op_is_load(op)) |=> (remain != '0));

  // R4: without an accept event the volume and latch hold
  p_idle_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !evt_fall |=> ($stable(vol) && $stable(cmd_q)));

endmodule

// File: rtl/chan_router.sv
module chan_router
  import snd_cmd_pkg::*;
#(
  parameter int LVL_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             o_wr,
  input  logic [LVL_W:0]   o_data,
  input  logic             r_wr,
  input  logic [LVL_W-1:0] r_data,
  output logic [LVL_W-1:0] ch0,
  output logic [LVL_W-1:0] ch1,
  output logic [LVL_W-1:0] ch2
);
  logic sel_hi;
  assign sel_hi = steer_hi(o_data);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ch0 <= '0;
      ch1 <= '0;
      ch2 <= '0;
    end else begin
      if (o_wr && !sel_hi) ch0 <= o_data[LVL_W-1:0];
      if (o_wr &&  sel_hi) ch1 <= o_data[LVL_W-1:0];
      if (r_wr)            ch2 <= r_data;
    end
  end

  // R10: a write with bit 4 clear lands on channel 0 and spares channel 1
  p_ch0_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (o_wr && !o_data[LVL_W]) |=> (ch0 == $past(o_data[LVL_W-1:0]) && $stable(ch1)));

  // R10: a write with bit 4 set lands on channel 1 and spares channel 0
  p_ch1_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (o_wr && o_data[LVL_W]) |=> (ch1 == $past(o_data[LVL_W-1:0]) && $stable(ch0)));

  // R11: second port drives channel 2 only
  p_ch2_write_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (r_wr && !o_wr) |=> (ch2 == $past(r_data) && $stable(ch0) && $stable(ch1)));

endmodule

// File: rtl/snd_cmd_parser.sv
module snd_cmd_parser
  import snd_cmd_pkg::*;
#(
  parameter int A_BYTES     = 4,
  parameter int B_BYTES     = 4,
  parameter int C_BYTES     = 5,
  parameter int SYNC_STAGES = 2,
  parameter int LVL_W       = 4,
  localparam int CNT_W      = 3
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [BYTE_W-1:0]         host_data,
  input  logic                      host_stb_n,
  input  logic                      port_o_wr,
  input  logic [LVL_W:0]            port_o_data,
  input  logic                      port_r_wr,
  input  logic [LVL_W-1:0]          port_r_data,
  output logic [NIB_W-1:0]          cmd_hi,
  output logic [NIB_W-1:0]          cmd_lo,
  output logic                      play_a,
  output logic                      play_b,
  output logic                      play_c,
  output logic [A_BYTES*BYTE_W-1:0] prm_a,
  output logic [B_BYTES*BYTE_W-1:0] prm_b,
  output logic [C_BYTES*BYTE_W-1:0] prm_c,
  output logic [NIB_W-1:0]          vol_c,
  output logic [LVL_W-1:0]          chan0,
  output logic [LVL_W-1:0]          chan1,
  output logic [LVL_W-1:0]          chan2
);
  logic              evt_fall;
  logic [BYTE_W-1:0] cmd_q;
  logic              wr_a, wr_b, wr_c;
  logic [CNT_W-1:0]  wr_idx;
  logic [BYTE_W-1:0] wr_data;

  strobe_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .stb_n(host_stb_n), .evt_fall(evt_fall));

  cmd_decoder #(.A_BYTES(A_BYTES), .B_BYTES(B_BYTES), .C_BYTES(C_BYTES),
                .CNT_W(CNT_W)) u_dec (
    .clk(clk), .rst_n(rst_n), .evt_fall(evt_fall), .din(host_data),
    .cmd_q(cmd_q), .play_a(play_a), .play_b(play_b), .play_c(play_c),
    .wr_a(wr_a), .wr_b(wr_b), .wr_c(wr_c), .wr_idx(wr_idx),
    .wr_data(wr_data), .vol(vol_c));

  param_bank #(.NBYTES(A_BYTES), .IDX_W(CNT_W)) u_bank_a (
    .clk(clk), .rst_n(rst_n), .wr(wr_a), .idx(wr_idx), .wdata(wr_data), .bank(prm_a));
  param_bank #(.NBYTES(B_BYTES), .IDX_W(CNT_W)) u_bank_b (
    .clk(clk), .rst_n(rst_n), .wr(wr_b), .idx(wr_idx), .wdata(wr_data), .bank(prm_b));
  param_bank #(.NBYTES(C_BYTES), .IDX_W(CNT_W)) u_bank_c (
    .clk(clk), .rst_n(rst_n), .wr(wr_c), .idx(wr_idx), .wdata(wr_data), .bank(prm_c));

  chan_router #(.LVL_W(LVL_W)) u_route (
    .clk(clk), .rst_n(rst_n), .o_wr(port_o_wr), .o_data(port_o_data),
    .r_wr(port_r_wr), .r_data(port_r_data), .ch0(chan0), .ch1(chan1), .ch2(chan2));

  assign cmd_hi = cmd_q[BYTE_W-1:NIB_W];
  assign cmd_lo = cmd_q[NIB_W-1:0];

  // R3: triggers are mutually exclusive
  p_play_onehot_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({play_a, play_b, play_c}));

  // R3: each trigger lasts a single cycle
  p_play_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (play_a || play_b || play_c) |=> !(play_a || play_b || play_c));

  // R2: a trigger coincides with a fresh accept of the nibble latch
  p_play_after_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(play_a) |-> (cmd_hi == OP_PLAY_A));

endmodule

// File: tb/snd_cmd_parser_tb.sv
module snd_cmd_parser_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] host_data = 8'h00;
  logic       host_stb_n = 1'b1;
  logic       port_o_wr = 1'b0;
  logic [4:0] port_o_data = '0;
  logic       port_r_wr = 1'b0;
  logic [3:0] port_r_data = '0;
  logic [3:0] cmd_hi, cmd_lo, vol_c, chan0, chan1, chan2;
  logic       play_a, play_b, play_c;
  logic [31:0] prm_a, prm_b;
  logic [39:0] prm_c;

  always #2 clk = ~clk;

  snd_cmd_parser u_dut (
    .clk(clk), .rst_n(rst_n), .host_data(host_data), .host_stb_n(host_stb_n),
    .port_o_wr(port_o_wr), .port_o_data(port_o_data), .port_r_wr(port_r_wr),
    .port_r_data(port_r_data), .cmd_hi(cmd_hi), .cmd_lo(cmd_lo),
    .play_a(play_a), .play_b(play_b), .play_c(play_c), .prm_a(prm_a),
    .prm_b(prm_b), .prm_c(prm_c), .vol_c(vol_c), .chan0(chan0),
    .chan1(chan1), .chan2(chan2));

  int n_chk = 0, n_fail = 0;
  int seen_a = 0, seen_b = 0, seen_c = 0;
  int exp_na = 0, exp_nb = 0, exp_nc = 0;
  logic [7:0] ea [4];
  logic [7:0] eb [4];
  logic [7:0] ec [5];
  logic [3:0] evol = '0, e0 = '0, e1 = '0, e2 = '0;
  int m_rem = 0, m_tgt = 0, m_idx = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (play_a) seen_a++;
      if (play_b) seen_b++;
      if (play_c) seen_c++;
    end
  end

  task automatic chk(input logic ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // expected behaviour from the byte order alone
  task automatic model(input logic [7:0] b);
    if (m_rem != 0) begin
      case (m_tgt)
        0: ea[m_idx] = b;
        1: eb[m_idx] = b;
        default: ec[m_idx] = b;
      endcase
      m_idx++; m_rem--;
    end else begin
      case (b[7:4])
        4'd1: exp_na++;
        4'd2: exp_nb++;
        4'd5: exp_nc++;
        4'd3: begin m_tgt = 0; m_rem = 4; m_idx = 0; end
        4'd4: begin m_tgt = 1; m_rem = 4; m_idx = 0; end
        4'd6: begin m_tgt = 2; m_rem = 5; m_idx = 0; end
        4'd7: evol = b[3:0];
        default: ;
      endcase
    end
  endtask

  task automatic send(input logic [7:0] b);
    @(negedge clk);
    host_data = b; host_stb_n = 1'b0;
    model(b);
    repeat (6) @(negedge clk);
    host_stb_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic check_all(input string req);
    logic [31:0] pa, pb;
    logic [39:0] pc;
    pa = {ea[3], ea[2], ea[1], ea[0]};
    pb = {eb[3], eb[2], eb[1], eb[0]};
    pc = {ec[4], ec[3], ec[2], ec[1], ec[0]};
    chk({cmd_hi, cmd_lo} == host_data, "R2 latch", {cmd_hi, cmd_lo}, host_data);
    chk(seen_a == exp_na && seen_b == exp_nb && seen_c == exp_nc, {req, " triggers"},
        {seen_a[15:0], seen_b[15:0], seen_c[15:0]}, {exp_na[15:0], exp_nb[15:0], exp_nc[15:0]});
    chk(vol_c == evol, {req, " R9 volume"}, vol_c, evol);
    chk(prm_a == pa, {req, " R5 bank A"}, prm_a, pa);
    chk(prm_b == pb, {req, " R6 bank B"}, prm_b, pb);
    chk(prm_c == pc, {req, " R7 bank C"}, prm_c, pc);
  endtask

  initial begin
    #(200000 * 4);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    foreach (ea[i]) ea[i] = '0;
    foreach (eb[i]) eb[i] = '0;
    foreach (ec[i]) ec[i] = '0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk({cmd_hi, cmd_lo, vol_c, chan0, chan1, chan2} == '0, "R1 regs", {cmd_hi, cmd_lo, vol_c, chan0, chan1, chan2}, 0);
    chk(prm_a == '0 && prm_b == '0 && prm_c == '0, "R1 banks", prm_c, 0);
    chk({play_a, play_b, play_c} == 3'b000, "R1 triggers", {play_a, play_b, play_c}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R2: cycle timing of one accept, long low period
    host_data = 8'h1A; host_stb_n = 1'b0; model(8'h1A);
    @(negedge clk); @(negedge clk);
    chk({cmd_hi, cmd_lo} == 8'h00 && !play_a, "R2 not yet", {cmd_hi, cmd_lo}, 8'h00);
    @(negedge clk);
    chk({cmd_hi, cmd_lo} == 8'h1A, "R2 third edge", {cmd_hi, cmd_lo}, 8'h1A);
    chk(play_a == 1'b1, "R3 pulse start", play_a, 1);
    @(negedge clk);
    chk(play_a == 1'b0, "R3 pulse end", play_a, 0);
    repeat (30) @(negedge clk);
    chk(seen_a == 1, "R2 single accept", seen_a, 1);
    host_stb_n = 1'b1;
    repeat (4) @(negedge clk);

    // sweep every opcode; loads are followed by command-like parameter bytes (R8)
    for (int op = 0; op < 16; op++) begin
      logic [7:0] cb;
      string tag;
      cb = {op[3:0], 4'((op * 3 + 1) & 15)};
      tag = (op == 1 || op == 2 || op == 5) ? "R3" :
            (op == 3) ? "R5" : (op == 4) ? "R6" : (op == 6) ? "R7" :
            (op == 7) ? "R9" : "R4";
      send(cb);
      check_all(tag);
      if (op == 3 || op == 4 || op == 6) begin
        int n;
        n = (op == 6) ? 5 : 4;
        for (int k = 0; k < n; k++) begin
          logic [7:0] pbyte;
          pbyte = {4'((op + k) % 8), 4'((op * 5 + k * 7) & 15)};
          send(pbyte);
          check_all("R8");
        end
      end
    end
    // second round with different data to refill every bank
    send(8'h7F); check_all("R9");
    send(8'h6E); for (int k = 0; k < 5; k++) begin send(8'((k * 53 + 17) & 255)); check_all("R7"); end
    send(8'h30); for (int k = 0; k < 4; k++) begin send(8'((k * 91 + 5) & 255)); check_all("R5"); end
    send(8'h41); for (int k = 0; k < 4; k++) begin send(8'((k * 29 + 200) & 255)); check_all("R6"); end
    send(8'h25); check_all("R3");

    // R10: all first-port values
    for (int v = 0; v < 32; v++) begin
      @(negedge clk);
      port_o_wr = 1'b1; port_o_data = 5'(v);
      if (v >= 16) e1 = 4'(v); else e0 = 4'(v);
      @(negedge clk);
      port_o_wr = 1'b0;
      chk(chan0 == e0 && chan1 == e1, "R10 steer", {chan0, chan1}, {e0, e1});
    end
    // R11: all second-port values
    for (int v = 0; v < 16; v++) begin
      @(negedge clk);
      port_r_wr = 1'b1; port_r_data = 4'(15 - v);
      e2 = 4'(15 - v);
      @(negedge clk);
      port_r_wr = 1'b0;
      chk(chan2 == e2 && chan0 == e0 && chan1 == e1, "R11 chan2", {chan0, chan1, chan2}, {e0, e1, e2});
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule